// File: doc/BRIEF.md
# Programmable Wait-State Generator

This block stretches processor bus accesses by a programmable number of stall cycles. Six address spaces each have their own 3-bit wait field: program memory, data memory, and four I/O regions. The fields sit in one memory-mapped configuration word. When the core raises an access strobe, the block picks the field for the selected space, turns it into a cycle count, and pulls `ready` low for exactly that many cycles.

A single mode bit changes how every field is read. With the bit clear, a field value N means N stall cycles (0 to 7). With the bit set, it means 2N+1 stall cycles (1 to 15). This doubles the reach without widening any field. The configuration word lives at word address 0x3FFE of the data space, and it is written and read through a simple register port.

Top module: `wait_state_gen`

## Requirements
- R1: After reset, every wait field holds 7 and the mode bit is 0. The configuration word therefore reads back as 0x03FFFF.
- R2: With the mode bit at 0, an access to a space whose field holds N keeps `ready` low for exactly N cycles.
- R3: With the mode bit at 1, an access to a space whose field holds N keeps `ready` low for exactly 2N+1 cycles.
- R4: The `acc_space` codes select the fields as follows: 0 program memory, bits [2:0]; 1 data memory, bits [5:3]; 2 to 5 I/O regions 0 to 3, bits [8:6], [11:9], [14:12] and [17:15]. The mode bit is bit 18. Codes 6 and 7 give zero wait states.
- R5: An access with zero wait states keeps `ready` high in the strobe cycle, so it completes in one cycle.
- R6: A stall starts in the strobe cycle and `ready` is high whenever no stall is in progress.
- R7: A register write takes effect only when `reg_addr` equals 0x3FFE. Writes to any other address leave the configuration unchanged.
- R8: A read at 0x3FFE returns exactly the bits last written to [18:0], and bits [23:19] read as zero. A read at any other address returns zero.
- R9: A configuration write does not change a stall count that is already loaded. This holds when the write lands during the stall and when it lands in the same cycle as the strobe; only later accesses use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access strobe, one cycle per access |
| acc_space | input | 3 | Target space code of the access |
| ready | output | 1 | High when the access may complete; low while stalling |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 14 | Register port word address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data, combinational on `reg_addr` |

## Verification
The assertions assume that the core never raises `acc_req` while `ready` is low, because a stalled core cannot issue a new access. The bench follows this rule: it starts each access only after it has seen `ready` return high. It sweeps every field value in both modes across all six spaces and the two unassigned codes, and it counts the low cycles of `ready` against the arithmetic value of N or 2N+1. Separate sequences place configuration writes mid-stall, in the strobe cycle, and at wrong addresses.

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 24,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 14'h3FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic [2:0]        acc_space,
  output logic              ready,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int CFG_W = 19;
  localparam logic [CFG_W-1:0] CFG_RST = {1'b0, {18{1'b1}}};

  logic [CFG_W-1:0] cfg;
  logic [3:0]       cnt;
  logic [2:0]       fld;
  logic [3:0]       waits;
  logic             busy, hit;

  assign hit  = (reg_addr == CFG_ADDR);
  assign busy = (cnt != 4'd0);

  always_comb begin
    case (acc_space)
      3'd0: fld = cfg[2:0];
      3'd1: fld = cfg[5:3];
      3'd2: fld = cfg[8:6];
      3'd3: fld = cfg[11:9];
      3'd4: fld = cfg[14:12];
      3'd5: fld = cfg[17:15];
      default: fld = 3'd0;
    endcase
  end

  assign waits = (acc_space > 3'd5) ? 4'd0 :
                 cfg[18] ? {fld, 1'b1} : {1'b0, fld};

  assign ready     = !busy && !(acc_req && waits != 4'd0);
  assign reg_rdata = hit ? {{(DATA_W-CFG_W){1'b0}}, cfg} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg <= CFG_RST;
    else if (reg_we && hit)
      cfg <= reg_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= 4'd0;
    else if (busy)
      cnt <= cnt - 4'd1;
    else if (acc_req && waits != 4'd0)
      cnt <= waits - 4'd1;
  end

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == CFG_ADDR) |=> $stable(reg_rdata) || $past(reg_addr) != reg_addr);

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cnt == $past(cnt) - 4'd1);

  // R3
  alt_mode_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && ready == 1'b0 && !busy) || !(cfg[18] && acc_req && !busy && acc_space <= 3'd5));

  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:CFG_W] == '0);

  // R9
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> cnt == $past(cnt) - 4'd1);

  // R5
  zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !busy && acc_space > 3'd5) |-> ready);
endmodule

// File: tb/wait_state_gen_test.sv
module wait_state_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_req = 0;
  logic [2:0]  acc_space = 0;
  logic        ready;
  logic        reg_we = 0;
  logic [13:0] reg_addr = 0;
  logic [23:0] reg_wdata = 0;
  logic [23:0] reg_rdata;
  int tests = 0, fails = 0;

  wait_state_gen uut (.*);

  always #5 clk = ~clk;

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input [13:0] a, input [23:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = 14'h3FFE;
  endtask

  task automatic rd(input [13:0] a, output [23:0] d);
    reg_addr = a; #1; d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic measure(input [2:0] sp, output int n, output bit first);
    n = 0; acc_space = sp; acc_req = 1; #1;
    first = ready;
    if (!ready) n++;
    @(negedge clk); acc_req = 0; #1;
    while (!ready && n < 40) begin n++; @(negedge clk); #1; end
    @(negedge clk);
  endtask

  initial begin
    logic [23:0] d;
    int n;
    bit first;
    reg_addr = 14'h3FFE;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R6 idle ready after reset", ready, 1);
    rd(14'h3FFE, d);
    check("R1 reset config", d, 24'h03FFFF);
    measure(3'd3, n, first);
    check("R1 reset field gives 7 waits", n, 7);

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 8; s++)
        for (int v = 0; v < 8; v++) begin
          logic [23:0] cw;
          int exp;
          cw = {5'd0, m[0], 18'd0};
          for (int f = 0; f < 6; f++) cw[f*3 +: 3] = (f == s) ? v[2:0] : 3'(7 - f);
          wr(14'h3FFE, cw);
          exp = (s > 5) ? 0 : (m == 1 ? 2*v + 1 : v);
          measure(s[2:0], n, first);
          if (s > 5) check("R4 unassigned code zero waits", n, exp);
          else if (m == 1) check("R3 alt mode 2N+1 waits", n, exp);
          else check("R2 normal mode N waits", n, exp);
          if (exp == 0) check("R5 zero-wait ready in strobe cycle", first, 1);
          else check("R6 stall starts in strobe cycle", first, 0);
          if (v == 3 && s < 6) begin
            rd(14'h3FFE, d);
            check("R8 readback", d, cw);
          end
        end

    wr(14'h3FFE, 24'hFFFFFF);
    rd(14'h3FFE, d);
    check("R8 unused bits read zero", d, 24'h07FFFF);
    rd(14'h3FFD, d);
    check("R8 other address reads zero", d, 0);

    wr(14'h3FFE, 24'h000002);
    wr(14'h3FFC, 24'h000005);
    wr(14'h1FFE, 24'h000006);
    rd(14'h3FFE, d);
    check("R7 wrong-address write ignored", d, 24'h000002);
    measure(3'd0, n, first);
    check("R7 wait unchanged after wrong-address write", n, 2);

    wr(14'h3FFE, 24'h000005);
    acc_space = 0; acc_req = 1; #1;
    n = ready ? 0 : 1;
    @(negedge clk); acc_req = 0;
    reg_we = 1; reg_addr = 14'h3FFE; reg_wdata = 24'h000001; #1;
    if (!ready) n++;
    @(negedge clk); reg_we = 0; #1;
    while (!ready && n < 40) begin n++; @(negedge clk); #1; end
    @(negedge clk);
    check("R9 mid-stall write keeps count", n, 5);
    measure(3'd0, n, first);
    check("R9 later access uses new value", n, 1);

    wr(14'h3FFE, 24'h000004);
    acc_space = 0; acc_req = 1;
    reg_we = 1; reg_addr = 14'h3FFE; reg_wdata = 24'h000006; #1;
    n = ready ? 0 : 1;
    @(negedge clk); acc_req = 0; reg_we = 0; #1;
    while (!ready && n < 40) begin n++; @(negedge clk); #1; end
    @(negedge clk);
    check("R9 same-cycle write uses old value", n, 4);
    measure(3'd0, n, first);
    check("R9 next access sees new value", n, 6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule